// File: doc/BRIEF.md
# Ethernet Receive Frame Screen

This block sits between the byte deserializer of an Ethernet receiver and its receive FIFO. Bytes arrive one per `byte_vld` strobe while `carrier` is high. A frame begins at the rising edge of `carrier` and ends at its falling edge. The block forwards the bytes to the FIFO with an end-of-frame flag on the last byte written. It either strips the trailing four FCS bytes or passes them through. At the end of each frame it judges the frame against five faults: FIFO overrun, bad CRC, a frame that is too short, a foreign destination address, and a status word that was overwritten before it was read.

Each fault sets its own bit in a status word. The word stays pending until the host acknowledges it. A one-cycle `drop` pulse tells the FIFO side to discard the frame whenever a fault is present whose enable bit in `irq_en` is clear. Two further options are available. The first makes the block ignore frames that start while the local transmitter is active. The second fires `drop` with a fixed short latency after carrier falls, instead of waiting for the last FIFO write.

Top module: `rx_frame_screen`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `fifo_wr`, `fifo_eof`, `drop`, `stat_pend` and `stat_word` are all zero.
- R2: With `keep_fcs` = 0, the bytes written to the FIFO are the frame's bytes in arrival order, minus its last four bytes. `fifo_eof` is high on the last write of the frame and on no other write.
- R3: With `keep_fcs` = 1, every byte of the frame is written in arrival order, including the four FCS bytes, and `fifo_eof` marks the final FCS byte.
- R4: A CRC is run over all bytes of the frame, FCS included. It is a reflected CRC-32 with polynomial 0xEDB88320, starting from all ones, with each byte fed LSB first. If the register does not end at 0xDEBB20E3, status bit 1 (CRC fault) is set.
- R5: A frame of fewer than MIN_LEN bytes (default 64), FCS included, sets status bit 2 (short frame).
- R6: The first six bytes are the destination address. The first byte is compared with `station_addr[47:40]` and the sixth with `station_addr[7:0]`. If these bytes match neither `station_addr` nor all ones, status bit 3 (address) is set.
- R7: No FIFO write occurs in the cycle after one in which `fifo_full` was high. A byte that meets a full FIFO is lost and sets status bit 0 (overrun).
- R8: At the end of each accepted frame, `stat_pend` rises and `stat_word` shows that frame's fault bits, using positions 0 to 4 as given in R4 to R7 and R9. `stat_pend` stays high until a cycle with `stat_ack` high.
- R9: If a frame ends while `stat_pend` is high and `stat_ack` is low, `stat_word` keeps its previous bits and also sets bit 4 (status lost). `stat_pend` stays high.
- R10: `drop` is a single-cycle pulse, issued once per frame when at least one fault bit of that frame is set and the matching bit of `irq_en` (same positions) is 0.
- R11: With `own_tx_block` = 1 and `tx_active` high at the carrier rise, the frame causes no FIFO write, no `drop` and no change to `stat_pend` or `stat_word`. With `own_tx_block` = 0, such a frame is received normally.
- R12: With `fast_drop` = 1, `drop` is high in the cycle after the first clock edge that samples `carrier` low. That is well within four cycles of the carrier fall. The faults judged are those known at that edge.
- R13: With `fast_drop` = 0, `drop` is issued in the same cycle as the frame's last FIFO write (the one with `fifo_eof`), or after the last flush step if nothing remains to write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier | input | 1 | Carrier sense; frame boundaries |
| byte_vld | input | 1 | One-cycle strobe for each received byte |
| byte_dat | input | 8 | Received byte |
| tx_active | input | 1 | Local transmitter busy |
| station_addr | input | 48 | Own station address, first byte in the high bits |
| keep_fcs | input | 1 | Pass the FCS bytes to the FIFO |
| own_tx_block | input | 1 | Ignore frames that start during own transmission |
| fast_drop | input | 1 | Issue discard right after the carrier falls |
| irq_en | input | 5 | Per-fault enable; a set bit suppresses discard for that fault |
| fifo_full | input | 1 | Receive FIFO cannot accept a byte |
| stat_ack | input | 1 | Host acknowledges the pending status |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_dat | output | 8 | FIFO write byte |
| fifo_eof | output | 1 | Last byte of the frame |
| drop | output | 1 | Discard the current frame |
| stat_pend | output | 1 | Status word waiting for acknowledge |
| stat_word | output | 5 | Fault bits of the last reported frame |

## Verification
The assertions check the local rules on every cycle. No write follows a full FIFO, the end-of-frame flag never appears without a write, `drop` never lasts longer than one cycle, a pending status holds until it is acknowledged, a fast discard follows a carrier fall, and a frame ignored during transmission stays silent. Other behaviours can only be shown by the bench's scenarios, because they depend on the whole frame: the CRC residue, FCS stripping against FCS keeping, the short and address faults, masking by `irq_en`, and the status-lost case on back-to-back frames. The bench checks these against a model built from byte queues.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
   localparam int NCAUSE = 5;
   localparam int C_OVF   = 0;
   localparam int C_CRC   = 1;
   localparam int C_SHORT = 2;
   localparam int C_ADDR  = 3;
   localparam int C_LOST  = 4;
   localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;
   localparam logic [31:0] CRC_POLY    = 32'hEDB88320;

   typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_SKIP, ST_FLUSH} rxf_state_t;

   function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
         else             r = r >> 1;
      end
      return r;
   endfunction
endpackage

// File: rtl/rxf_crc_acc.sv
`timescale 1ns/1ps
module rxf_crc_acc
   import rxf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init,
   input  logic       step,
   input  logic [7:0] din,
   output logic       crc_ok
);
   logic [31:0] crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || init) crc_q <= '1;
      else if (step)      crc_q <= crc_byte(crc_q, din);
   end

   assign crc_ok = (crc_q == CRC_RESIDUE);
endmodule

// File: rtl/rxf_hold_line.sv
`timescale 1ns/1ps
module rxf_hold_line #(
   parameter int DEPTH = 5,
   localparam int HW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [7:0]    din,
   output logic [7:0]    oldest,
   output logic [HW-1:0] held
);
   logic [7:0] sr [DEPTH];

   generate
      if (DEPTH < 2) begin : g_depth_bad
         $error("rxf_hold_line needs DEPTH of at least 2");
      end
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk) if (push) sr[0] <= din;
         end else begin : g_body
            always_ff @(posedge clk) if (push) sr[i] <= sr[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr)                    held <= '0;
      else if (push && held != HW'(DEPTH))  held <= held + 1'b1;
      else if (pop && held != '0)           held <= held - 1'b1;
   end

   always_comb begin
      oldest = sr[0];
      for (int k = 0; k < DEPTH; k++)
         if (held == HW'(k + 1)) oldest = sr[k];
   end

   a_r2_no_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop));
endmodule

// File: rtl/rx_frame_screen.sv
`timescale 1ns/1ps
module rx_frame_screen
   import rxf_pkg::*;
#(
   parameter int MIN_LEN    = 64,
   parameter int ADDR_BYTES = 6,
   parameter int FCS_LEN    = 4,
   parameter bit BCAST_EN   = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      carrier,
   input  logic                      byte_vld,
   input  logic [7:0]                byte_dat,
   input  logic                      tx_active,
   input  logic [8*ADDR_BYTES-1:0]   station_addr,
   input  logic                      keep_fcs,
   input  logic                      own_tx_block,
   input  logic                      fast_drop,
   input  logic [NCAUSE-1:0]         irq_en,
   input  logic                      fifo_full,
   input  logic                      stat_ack,
   output logic                      fifo_wr,
   output logic [7:0]                fifo_dat,
   output logic                      fifo_eof,
   output logic                      drop,
   output logic                      stat_pend,
   output logic [NCAUSE-1:0]         stat_word
);
   localparam int DEPTH = FCS_LEN + 1;
   localparam int HW    = $clog2(DEPTH + 1);
   localparam int CW    = $clog2(MIN_LEN + 1);

   generate
      if (FCS_LEN != 4 || MIN_LEN < ADDR_BYTES + FCS_LEN) begin : g_param_bad
         $error("rx_frame_screen: FCS_LEN must be 4 and MIN_LEN must cover address and FCS");
      end
   endgenerate

   rxf_state_t        state;
   logic              crs_q, rise, fall;
   logic [CW-1:0]     cnt;
   logic              st_ok, bc_ok, ovf_q, crc_ok;
   logic [NCAUSE-1:0] causes_q, cur_vec, dec_vec, fin_vec;
   logic              push, pop, want, weof, dec_now, lost;
   logic [7:0]        oldest;
   logic [HW-1:0]     held, floor_c, floor_p1;
   logic [ADDR_BYTES-1:0] st_miss, bc_miss;

   assign rise = carrier && !crs_q;
   assign fall = crs_q && !carrier;

   // destination address comparison, one lane per address byte
   generate
      for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_addr
         assign st_miss[i] = (cnt == CW'(i)) &&
                             (byte_dat != station_addr[8*(ADDR_BYTES-1-i) +: 8]);
         if (BCAST_EN) begin : g_bc
            assign bc_miss[i] = (cnt == CW'(i)) && (byte_dat != 8'hFF);
         end else begin : g_nobc
            assign bc_miss[i] = (cnt == CW'(i));
         end
      end
   endgenerate

   rxf_crc_acc u_crc (
      .clk(clk), .rst_n(rst_n), .init(state == ST_IDLE),
      .step(push), .din(byte_dat), .crc_ok(crc_ok)
   );

   rxf_hold_line #(.DEPTH(DEPTH)) u_hold (
      .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE),
      .push(push), .pop(pop), .din(byte_dat),
      .oldest(oldest), .held(held)
   );

   always_comb begin
      cur_vec          = '0;
      cur_vec[C_OVF]   = ovf_q;
      cur_vec[C_CRC]   = !crc_ok;
      cur_vec[C_SHORT] = (cnt < CW'(MIN_LEN));
      cur_vec[C_ADDR]  = !(st_ok || bc_ok);
   end

   assign floor_c  = keep_fcs ? '0 : HW'(FCS_LEN);
   assign floor_p1 = floor_c + 1'b1;

   always_comb begin
      push = 1'b0; pop = 1'b0; want = 1'b0; weof = 1'b0;
      dec_now = 1'b0; dec_vec = causes_q;
      case (state)
         ST_RECV: begin
            if (byte_vld) begin
               push = 1'b1;
               want = (held == HW'(DEPTH));
            end
            if (fall) begin
               dec_vec = cur_vec;
               dec_now = fast_drop;
            end
         end
         ST_FLUSH: begin
            if (held > floor_c) begin
               want = 1'b1;
               pop  = 1'b1;
               weof = (held == floor_p1);
            end
            if (held <= floor_p1) begin
               dec_now = !fast_drop;
               dec_vec[C_OVF] = causes_q[C_OVF] || (want && fifo_full);
            end
         end
         default: ;
      endcase
   end

   assign lost = stat_pend && !stat_ack;
   always_comb begin
      fin_vec = dec_vec;
      fin_vec[C_LOST] = lost;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE; crs_q <= 1'b0;
         fifo_wr <= 1'b0; fifo_dat <= '0; fifo_eof <= 1'b0; drop <= 1'b0;
         stat_pend <= 1'b0; stat_word <= '0;
         cnt <= '0; st_ok <= 1'b1; bc_ok <= 1'b1; ovf_q <= 1'b0; causes_q <= '0;
      end else begin
         crs_q    <= carrier;
         fifo_wr  <= want && !fifo_full;
         fifo_dat <= oldest;
         fifo_eof <= weof && !fifo_full;
         drop     <= dec_now && |(fin_vec & ~irq_en);

         if (dec_now) begin
            stat_pend <= 1'b1;
            if (lost) stat_word[C_LOST] <= 1'b1;
            else      stat_word <= fin_vec;
         end else if (stat_ack) begin
            stat_pend <= 1'b0;
         end

         case (state)
            ST_IDLE: if (rise) begin
               state <= (own_tx_block && tx_active) ? ST_SKIP : ST_RECV;
               cnt <= '0; st_ok <= 1'b1; bc_ok <= 1'b1; ovf_q <= 1'b0;
            end
            ST_RECV: begin
               if (push) begin
                  if (cnt != CW'(MIN_LEN)) cnt <= cnt + 1'b1;
                  if (|st_miss) st_ok <= 1'b0;
                  if (|bc_miss) bc_ok <= 1'b0;
               end
               if (want && fifo_full) ovf_q <= 1'b1;
               if (fall) begin
                  causes_q <= cur_vec;
                  state    <= ST_FLUSH;
               end
            end
            ST_FLUSH: begin
               if (want && fifo_full) causes_q[C_OVF] <= 1'b1;
               if (held <= floor_p1) state <= ST_IDLE;
            end
            ST_SKIP: if (!carrier) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   a_r7_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> $past(!fifo_full));
   a_r2_eof_with_write: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_eof |-> fifo_wr);
   a_r10_drop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> !drop);
   a_r8_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_pend && !stat_ack) |=> stat_pend);
   a_r12_fast_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && $past(fast_drop)) |-> $past(crs_q && !carrier));
   a_r11_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> (!fifo_wr && !drop));
endmodule

// File: tb/rx_frame_screen_test.sv
`timescale 1ns/1ps
module rx_frame_screen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        carrier = 1'b0, byte_vld = 1'b0, tx_active = 1'b0;
   logic [7:0]  byte_dat = '0;
   logic [47:0] station_addr = 48'h0A1B2C3D4E5F;
   logic        keep_fcs = 1'b0, own_tx_block = 1'b0, fast_drop = 1'b0;
   logic [4:0]  irq_en = '0;
   logic        fifo_full = 1'b0, stat_ack = 1'b0;
   logic        fifo_wr, fifo_eof, drop, stat_pend;
   logic [7:0]  fifo_dat;
   logic [4:0]  stat_word;

   int vectors = 0, miscompares = 0, cyc = 0, fall_cyc = 0, drops = 0;
   bit done = 1'b0;
   logic [8:0] expq[$];
   bit   pend_m = 1'b0;
   logic [4:0] word_m = '0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rx_frame_screen uut (
      .clk(clk), .rst_n(rst_n), .carrier(carrier), .byte_vld(byte_vld),
      .byte_dat(byte_dat), .tx_active(tx_active), .station_addr(station_addr),
      .keep_fcs(keep_fcs), .own_tx_block(own_tx_block), .fast_drop(fast_drop),
      .irq_en(irq_en), .fifo_full(fifo_full), .stat_ack(stat_ack),
      .fifo_wr(fifo_wr), .fifo_dat(fifo_dat), .fifo_eof(fifo_eof), .drop(drop),
      .stat_pend(stat_pend), .stat_word(stat_word)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // per-clock comparison against the expected write stream and drop timing
   always @(negedge clk) if (rst_n && !done) begin
      if (fifo_wr) begin
         if (expq.size() == 0) chk(1'b0, "R2 unexpected FIFO write", {fifo_eof, fifo_dat}, 0);
         else begin
            logic [8:0] e;
            e = expq.pop_front();
            chk({fifo_eof, fifo_dat} == e, "R2/R3 FIFO byte and eof", {fifo_eof, fifo_dat}, e);
         end
      end
      if (drop) begin
         drops++;
         if (fast_drop) chk(cyc == fall_cyc + 1, "R12 fast drop cycle", cyc, fall_cyc + 1);
         else chk((fifo_wr && fifo_eof) || expq.size() == 0, "R13 drop with last write",
                  {fifo_wr, fifo_eof}, 3);
      end
   end

   function automatic logic [31:0] crc_next(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r = c;
      for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
      return r;
   endfunction

   task automatic tick(); @(posedge clk); #2; endtask

   // kind: 0 station, 1 broadcast, 2 foreign
   task automatic send(input int n, input int kind, input bit bad, input bit full,
                       input bit tx, input string tag);
      logic [7:0]  q[$];
      logic [31:0] crc = '1;
      logic [4:0]  vec = '0;
      bit ignored;
      int exp_drops, nwr;
      for (int i = 0; i < 6; i++)
         q.push_back(kind == 1 ? 8'hFF : kind == 2 ? 8'h02 + 8'(i) : station_addr[8*(5-i) +: 8]);
      for (int i = 6; i < n - 4; i++) q.push_back(8'((i * 13 + 5) & 255));
      foreach (q[i]) crc = crc_next(crc, q[i]);
      for (int k = 0; k < 4; k++) q.push_back(~crc[8*k +: 8]);
      if (bad) q[7] = q[7] ^ 8'h01;
      ignored   = own_tx_block && tx;
      exp_drops = 0;
      if (!ignored) begin
         nwr = keep_fcs ? n : n - 4;
         if (!full) for (int i = 0; i < nwr; i++) expq.push_back({i == nwr - 1, q[i]});
         vec[0] = full; vec[1] = bad; vec[2] = (n < 64); vec[3] = (kind == 2);
         vec[4] = pend_m;
         if (pend_m) word_m[4] = 1'b1; else word_m = vec;
         pend_m = 1'b1;
         exp_drops = (|(vec & ~irq_en)) ? 1 : 0;
      end
      drops = 0;
      tx_active = tx; fifo_full = full;
      tick(); carrier = 1'b1;
      tick(); tick();
      foreach (q[i]) begin
         byte_dat = q[i]; byte_vld = 1'b1;
         tick(); byte_vld = 1'b0;
         tick(); tick(); tick();
      end
      carrier = 1'b0; fall_cyc = cyc;
      repeat (20) tick();
      fifo_full = 1'b0; tx_active = 1'b0;
      @(negedge clk);
      chk(expq.size() == 0, {tag, " all expected writes seen"}, expq.size(), 0);
      chk(drops == exp_drops, {tag, " R10 drop count"}, drops, exp_drops);
      chk(stat_pend == pend_m, {tag, " R8 pending"}, stat_pend, pend_m);
      chk(stat_word == word_m, {tag, " R8 status word"}, stat_word, word_m);
      expq.delete();
   endtask

   task automatic ack();
      tick(); stat_ack = 1'b1;
      tick(); stat_ack = 1'b0;
      pend_m = 1'b0;
      @(negedge clk);
      chk(stat_pend == 1'b0, "R8 acknowledge clears pending", stat_pend, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk({fifo_wr, fifo_eof, drop, stat_pend, stat_word} == '0, "R1 reset outputs",
          {fifo_wr, fifo_eof, drop, stat_pend, stat_word}, 0);
      tick(); rst_n = 1'b1;
      @(negedge clk);
      chk({fifo_wr, fifo_eof, drop, stat_pend, stat_word} == '0, "R1 first cycle after reset",
          {fifo_wr, fifo_eof, drop, stat_pend, stat_word}, 0);

      send(64, 0, 0, 0, 0, "R2 R6 good station frame, FCS stripped"); ack();
      keep_fcs = 1'b1;
      send(70, 1, 0, 0, 0, "R3 broadcast frame, FCS kept"); ack();
      keep_fcs = 1'b0; fast_drop = 1'b1;
      send(80, 0, 1, 0, 0, "R4 R12 bad CRC, fast discard"); ack();
      fast_drop = 1'b0;
      send(40, 0, 0, 0, 0, "R5 R13 short frame, slow discard"); ack();
      irq_en = 5'b01000;
      send(66, 2, 0, 0, 0, "R6 R10 foreign address, masked"); ack();
      irq_en = '0;
      send(66, 2, 0, 0, 0, "R6 foreign address, unmasked"); ack();
      fast_drop = 1'b1;
      send(68, 0, 0, 1, 0, "R7 overrun while FIFO full"); ack();
      fast_drop = 1'b0; own_tx_block = 1'b1;
      send(64, 0, 0, 0, 1, "R11 frame during own transmit ignored");
      own_tx_block = 1'b0;
      send(64, 0, 0, 0, 1, "R11 own transmit without blocking");
      keep_fcs = 1'b1; fast_drop = 1'b1;
      send(72, 0, 1, 0, 0, "R9 status lost on unread status"); ack();
      keep_fcs = 1'b0; fast_drop = 1'b0; irq_en = 5'b11111;
      send(30, 2, 1, 0, 0, "R10 all causes masked");
      send(64, 0, 0, 0, 0, "R9 R10 lost masked"); ack();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog: run did not complete, actual 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule